// File: doc/BRIEF.md
# Element-Pointer Short Load/Store Unit

This block accepts compact 16-bit memory instructions whose address is an unsigned displacement added to a dedicated element-pointer register. It recognises six encodings: signed byte load, unsigned byte load, byte store, signed halfword load, unsigned halfword load and word load. For each it takes the displacement field, scales it to a byte offset according to the access size, adds it to the pointer and issues one memory request with a size code, byte-lane enables and, for stores, the store data placed on the proper lanes.

Requests leave one clock after the instruction is presented. Load data returns on a separate valid strobe. The block then selects the addressed byte or halfword, sign- or zero-extends it as the opcode asks, and emits a writeback for the destination register in the next cycle. An access that is not naturally aligned is not sent to memory. Instead it raises a one-cycle misalignment flag. Only one load may be outstanding at a time.

Top module: `ep_ldst_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `misaligned` and `wb_en` are 0.
- R2: `instr[10:7]` = 0110 is a signed byte load and 0111 is a byte store. Both use displacement `instr[6:0]` as a byte offset. The address is `ep_value` plus the zero-extended displacement, modulo 2^32. `mem_we` is 1 only for the store. Size code: 0 = byte, 1 = halfword, 2 = word.
- R3: `instr[10:4]` = 0000110 is an unsigned byte load with byte offset `instr[3:0]`.
- R4: `instr[10:7]` = 1000 is a signed halfword load with offset `instr[6:0]`×2. `instr[10:4]` = 0000111 is an unsigned halfword load with offset `instr[3:0]`×2.
- R5: `instr[10:7]` = 1010 with `instr[0]` = 0 is a word load with offset `instr[6:1]`×4. With `instr[0]` = 1 the instruction is not recognised.
- R6: An unrecognised instruction produces no request, no misalignment flag and no writeback.
- R7: Byte enables address a 32-bit little-endian bus. A byte access sets bit `addr[1:0]`. A halfword access sets 0011 or 1100 according to `addr[1]`. A word access sets 1111.
- R8: Store data is the byte of `store_value[7:0]` copied to all four lanes.
- R9: The writeback value is the byte at lane `addr[1:0]`, or the halfword at `addr[1]`, of `mem_rdata`. It is sign-extended for signed loads and zero-extended for unsigned loads. A word is passed through unchanged.
- R10: A halfword at an odd address or a word at an address not a multiple of 4 raises `misaligned` for one cycle. It issues no request and no writeback, even if `mem_rvalid` follows.
- R11: `mem_req` or `misaligned` is high for exactly the one cycle after `instr_valid`. `wb_en` is high for the one cycle after `mem_rvalid` returns data for an outstanding load. `wb_reg` equals `instr[15:11]` of that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Short-format instruction |
| ep_value | input | 32 | Element-pointer register value |
| store_value | input | 32 | Contents of the source register for stores |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| misaligned | output | 1 | Access was not naturally aligned |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data word |
| wb_en | output | 1 | Register writeback strobe |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |

## Verification
The bench targets the displacement scaling of each size. A design that forgets the ×2 or ×4 shift, or that reads a word offset from `instr[5:0]`, produces addresses that miss by a small multiple. Pointers near 2^32 check that the displacement is zero-extended and that the sum wraps. Every lane is used with data whose top bit is set, so a swapped sign/zero extension or a wrong lane select shows up in the writeback. Misaligned halfwords and words, the word encoding with bit 0 set, and opcodes outside the six are sent with a trailing `mem_rvalid`. A design that still issued a request or wrote back a stale result would be caught.

// File: rtl/ep_ldst_pkg.sv
// Shared types for the element-pointer short load/store unit.
package ep_ldst_pkg;
    // Access size code placed on the memory request.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Fields produced by decoding one short instruction.
    typedef struct packed {
        logic       hit;    // one of the six encodings
        logic       store;  // byte store
        logic       sext;   // signed load
        acc_size_e  size;
        logic [7:0] disp;   // scaled byte offset
        logic [4:0] rdst;   // register field, bits 15:11
    } short_op_t;
endpackage

// File: rtl/ep_ldst_decode.sv
// Decodes a 16-bit short instruction into size, direction, signedness and
// scaled byte displacement. Assumes the caller qualifies the result with
// its own valid; an unrecognised pattern returns hit = 0.
module ep_ldst_decode
    import ep_ldst_pkg::*;
(
    input  logic [15:0] instr,
    output short_op_t   op
);
    // Match the opcode field and scale the displacement for the access size.
    always_comb begin
        op      = '0;
        op.rdst = instr[15:11];
        op.size = SZ_BYTE;
        if (instr[10:7] == 4'b0110) begin
            op.hit  = 1'b1;
            op.sext = 1'b1;
            op.disp = {1'b0, instr[6:0]};
        end else if (instr[10:7] == 4'b0111) begin
            op.hit   = 1'b1;
            op.store = 1'b1;
            op.disp  = {1'b0, instr[6:0]};
        end else if (instr[10:7] == 4'b1000) begin
            op.hit  = 1'b1;
            op.sext = 1'b1;
            op.size = SZ_HALF;
            op.disp = {instr[6:0], 1'b0};
        end else if (instr[10:7] == 4'b1010 && !instr[0]) begin
            op.hit  = 1'b1;
            op.size = SZ_WORD;
            op.disp = {instr[6:1], 2'b00};
        end else if (instr[10:4] == 7'b0000110) begin
            op.hit  = 1'b1;
            op.disp = {4'b0000, instr[3:0]};
        end else if (instr[10:4] == 7'b0000111) begin
            op.hit  = 1'b1;
            op.size = SZ_HALF;
            op.disp = {3'b000, instr[3:0], 1'b0};
        end
    end
endmodule

// File: rtl/ep_ldst_lane.sv
// Builds byte enables and lane-steered store data from the access size and
// the low address bits, and reports natural alignment. Assumes a
// little-endian bus of DATA_W bits with at least four byte lanes.
module ep_ldst_lane
    import ep_ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_B = $clog2(LANES)
)(
    input  acc_size_e         size,
    input  logic [LANE_B-1:0] addr_lo,
    input  logic [DATA_W-1:0] store_value,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic              aligned
);
    // Alignment: halfwords need an even address, words a lane-0 address.
    always_comb begin
        unique case (size)
            SZ_HALF: aligned = ~addr_lo[0];
            SZ_WORD: aligned = (addr_lo[1:0] == 2'b00);
            default: aligned = 1'b1;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_B-1:0] LANE_ID = LANE_B'(g);
        // Per-lane enable and replicated store byte.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    be[g]          = (addr_lo == LANE_ID);
                    wdata[8*g +: 8] = store_value[7:0];
                end
                SZ_HALF: begin
                    be[g]          = (addr_lo[1] == LANE_ID[1]);
                    wdata[8*g +: 8] = store_value[8*(g%2) +: 8];
                end
                default: begin
                    be[g]          = 1'b1;
                    wdata[8*g +: 8] = store_value[8*g +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/ep_ldst_extend.sv
// Picks the addressed byte or halfword out of a returned data word and
// sign- or zero-extends it. Assumes a little-endian bus of at least 32 bits.
module ep_ldst_extend
    import ep_ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANE_B = $clog2(DATA_W / 8)
)(
    input  acc_size_e         size,
    input  logic              sext,
    input  logic [LANE_B-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Lane selection and extension.
    always_comb begin
        sel_b = rdata[8*lane +: 8];
        sel_h = rdata[16*lane[1] +: 16];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sext & sel_b[7]}}, sel_b};
            SZ_HALF: result = {{(DATA_W-16){sext & sel_h[15]}}, sel_h};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/ep_ldst_unit.sv
// Element-pointer short load/store unit. Decodes the instruction, adds the
// scaled displacement to the pointer, issues a registered memory request
// (or a misalignment flag instead), and turns returned load data into a
// registered writeback. Assumes at most one load outstanding.
module ep_ldst_unit
    import ep_ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_B = $clog2(LANES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] ep_value,
    input  logic [DATA_W-1:0] store_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misaligned,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [4:0]        wb_reg,
    output logic [DATA_W-1:0] wb_data
);
    short_op_t          op;
    logic [ADDR_W-1:0]  eff_addr;
    logic [LANES-1:0]   be_c;
    logic [DATA_W-1:0]  wdata_c;
    logic               aligned;
    logic               accept;
    logic               pend_valid;
    logic [4:0]         pend_reg;
    acc_size_e          pend_size;
    logic               pend_sext;
    logic [LANE_B-1:0]  pend_lane;
    logic [DATA_W-1:0]  ext_c;

    ep_ldst_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    // Effective address: pointer plus zero-extended scaled displacement.
    always_comb eff_addr = ep_value + ADDR_W'(op.disp);

    ep_ldst_lane #(.DATA_W(DATA_W)) u_lane (
        .size        (op.size),
        .addr_lo     (eff_addr[LANE_B-1:0]),
        .store_value (store_value),
        .be          (be_c),
        .wdata       (wdata_c),
        .aligned     (aligned)
    );

    // Recognised instruction presented this cycle.
    always_comb accept = instr_valid & op.hit;

    // Request stage: one-cycle request or misalignment flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req    <= 1'b0;
            misaligned <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_size   <= 2'd0;
            mem_be     <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_req    <= accept & aligned;
            misaligned <= accept & ~aligned;
            if (accept & aligned) begin
                mem_we    <= op.store;
                mem_addr  <= eff_addr;
                mem_size  <= op.size;
                mem_be    <= be_c;
                mem_wdata <= wdata_c;
            end
        end
    end

    // Outstanding-load bookkeeping for the return path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_reg   <= '0;
            pend_size  <= SZ_BYTE;
            pend_sext  <= 1'b0;
            pend_lane  <= '0;
        end else if (accept & aligned & ~op.store) begin
            pend_valid <= 1'b1;
            pend_reg   <= op.rdst;
            pend_size  <= op.size;
            pend_sext  <= op.sext;
            pend_lane  <= eff_addr[LANE_B-1:0];
        end else if (mem_rvalid) begin
            pend_valid <= 1'b0;
        end
    end

    ep_ldst_extend #(.DATA_W(DATA_W)) u_ext (
        .size   (pend_size),
        .sext   (pend_sext),
        .lane   (pend_lane),
        .rdata  (mem_rdata),
        .result (ext_c)
    );

    // Writeback stage: register the extended result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_reg  <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= mem_rvalid & pend_valid;
            if (mem_rvalid & pend_valid) begin
                wb_reg  <= pend_reg;
                wb_data <= ext_c;
            end
        end
    end
endmodule

// File: rtl/ep_ldst_unit_chk.sv
// Protocol checks on the ports of ep_ldst_unit; attached by bind below.
module ep_ldst_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [LANES-1:0]  mem_be,
    input logic              misaligned,
    input logic              mem_rvalid,
    input logic              wb_en
);
    AST_REQ_OR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && misaligned)); // R10
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd0) |-> ($countones(mem_be) == 1)); // R7
    AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd1) |-> (!mem_addr[0] && $countones(mem_be) == 2)); // R10
    AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00 && &mem_be)); // R5
    AST_REQ_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || misaligned) |-> $past(instr_valid)); // R11
    AST_WB_AFTER_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(mem_rvalid)); // R11
endmodule

bind ep_ldst_unit ep_ldst_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_be      (mem_be),
    .misaligned  (misaligned),
    .mem_rvalid  (mem_rvalid),
    .wb_en       (wb_en)
);

// File: tb/ep_ldst_unit_test.sv
module ep_ldst_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] ep_value = '0;
    logic [31:0] store_value = '0;
    logic        mem_req, mem_we, misaligned, wb_en;
    logic [31:0] mem_addr, mem_wdata, wb_data;
    logic [1:0]  mem_size;
    logic [3:0]  mem_be;
    logic [4:0]  wb_reg;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ep_ldst_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ep_value(ep_value), .store_value(store_value), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .misaligned(misaligned),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference decode written from the requirement text.
    function automatic void model(input logic [15:0] i, output bit hit, output bit st,
                                  output bit sx, output logic [1:0] sz,
                                  output logic [7:0] d, output string tag);
        hit = 1; st = 0; sx = 0; sz = 2'd0; d = 0; tag = "R6";
        case (i[10:7])
            4'b0110: begin sx = 1; d = 8'(i[6:0]); tag = "R2"; end
            4'b0111: begin st = 1; d = 8'(i[6:0]); tag = "R2"; end
            4'b1000: begin sx = 1; sz = 2'd1; d = 8'(i[6:0]) * 8'd2; tag = "R4"; end
            4'b1010: begin
                if (i[0]) begin hit = 0; tag = "R5"; end
                else begin sz = 2'd2; d = 8'(i[6:1]) * 8'd4; tag = "R5"; end
            end
            default: begin
                if (i[10:4] == 7'b0000110) begin d = 8'(i[3:0]); tag = "R3"; end
                else if (i[10:4] == 7'b0000111) begin sz = 2'd1; d = 8'(i[3:0]) * 8'd2; tag = "R4"; end
                else hit = 0;
            end
        endcase
    endfunction

    function automatic logic [31:0] exp_ext(logic [31:0] r, logic [1:0] sz, bit sx, logic [1:0] a);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(r >> (8 * a));
        h = a[1] ? r[31:16] : r[15:0];
        if (sz == 2'd0) return sx ? {{24{b[7]}}, b} : {24'd0, b};
        if (sz == 2'd1) return sx ? {{16{h[15]}}, h} : {16'd0, h};
        return r;
    endfunction

    task automatic run_op(logic [15:0] i, logic [31:0] ep, logic [31:0] sv, logic [31:0] rd);
        bit hit, st, sx, ok;
        logic [1:0] sz;
        logic [7:0] d;
        logic [31:0] a;
        logic [3:0] be;
        logic [31:0] wd;
        string tag;
        model(i, hit, st, sx, sz, d, tag);
        a  = ep + {24'd0, d};
        ok = (sz == 2'd0) || (sz == 2'd1 && !a[0]) || (sz == 2'd2 && a[1:0] == 2'b00);
        be = (sz == 2'd0) ? 4'(1 << a[1:0]) : (sz == 2'd1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'hF;
        wd = (sz == 2'd0) ? {4{sv[7:0]}} : (sz == 2'd1) ? {2{sv[15:0]}} : sv;
        @(negedge clk);
        instr = i; ep_value = ep; store_value = sv; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (!hit) begin
            chk(tag, "req for unrecognised", {31'd0, mem_req}, 32'd0);
            chk("R6", "misaligned for unrecognised", {31'd0, misaligned}, 32'd0);
        end else if (!ok) begin
            chk("R10", "misaligned flag", {31'd0, misaligned}, 32'd1);
            chk("R10", "req on misaligned", {31'd0, mem_req}, 32'd0);
        end else begin
            chk(tag, "req", {31'd0, mem_req}, 32'd1);
            chk(tag, "address", mem_addr, a);
            chk(tag, "we", {31'd0, mem_we}, {31'd0, st});
            chk(tag, "size", {30'd0, mem_size}, {30'd0, sz});
            chk("R7", "byte enables", {28'd0, mem_be}, {28'd0, be});
            if (st) chk("R8", "store data", mem_wdata, wd);
        end
        if (!st) begin
            mem_rvalid = 1'b1; mem_rdata = rd;
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R11", "req one cycle", {31'd0, mem_req | misaligned}, 32'd0);
        if (hit && ok && !st) begin
            chk("R11", "wb_en", {31'd0, wb_en}, 32'd1);
            chk("R11", "wb_reg", {27'd0, wb_reg}, {27'd0, i[15:11]});
            chk("R9", "wb_data", wb_data, exp_ext(rd, sz, sx, a[1:0]));
        end else begin
            chk(hit ? (st ? "R2" : "R10") : "R6", "no writeback", {31'd0, wb_en}, 32'd0);
        end
        @(negedge clk);
        chk("R11", "wb one cycle", {31'd0, wb_en}, 32'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0703));
        repeat (3) @(negedge clk);
        chk("R1", "req in reset", {31'd0, mem_req}, 32'd0);
        chk("R1", "misaligned in reset", {31'd0, misaligned}, 32'd0);
        chk("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req after reset", {31'd0, mem_req | wb_en | misaligned}, 32'd0);
        // Directed corner cases.
        run_op({5'd3, 4'b0110, 7'h7F}, 32'hFFFF_FFF0, 0, 32'h80C0_E0F0);  // R2 wrap, lane 3
        run_op({5'd4, 4'b0111, 7'h05}, 32'h0000_1000, 32'hA5A5_5AC3, 0);  // R2 R8 store
        run_op({5'd5, 7'b0000110, 4'hF}, 32'h0000_2000, 0, 32'h8182_8384); // R3 lane 3
        run_op({5'd6, 4'b1000, 7'h7F}, 32'h0000_3000, 0, 32'h8001_7FFF);  // R4 upper half signed
        run_op({5'd7, 7'b0000111, 4'hF}, 32'h0000_4000, 0, 32'h9000_1234); // R4 unsigned
        run_op({5'd8, 4'b1010, 7'h7E}, 32'h0000_5000, 0, 32'hDEAD_BEEF);  // R5 word max disp
        run_op({5'd9, 4'b1010, 7'h01}, 32'h0000_5000, 0, 32'h1);          // R5 bit0 set
        run_op({5'd10, 4'b1111, 7'h00}, 32'h0000_6000, 0, 32'h1);         // R6
        run_op({5'd11, 4'b1000, 7'h02}, 32'h0000_7001, 0, 32'h1);         // R10 half odd
        run_op({5'd12, 4'b1010, 7'h02}, 32'h0000_7002, 0, 32'h1);         // R10 word
        for (int k = 0; k < 4; k++)
            run_op({5'(k), 4'b0110, 7'(k)}, 32'h0000_8000, 0, 32'h8899_AABB); // R9 lanes
        // Constrained random mix.
        for (int n = 0; n < 600; n++) begin
            logic [15:0] i;
            logic [31:0] ep;
            int sel;
            sel = $urandom % 8;
            i = 16'($urandom);
            case (sel)
                0: i[10:7] = 4'b0110;
                1: i[10:7] = 4'b0111;
                2: i[10:4] = 7'b0000110;
                3: i[10:7] = 4'b1000;
                4: i[10:4] = 7'b0000111;
                5: begin i[10:7] = 4'b1010; i[0] = 1'b0; end
                6: begin i[10:7] = 4'b1010; i[0] = 1'b1; end
                default: ;
            endcase
            ep = $urandom;
            if ($urandom % 2) ep[1:0] = 2'b00;
            run_op(i, ep, $urandom, $urandom);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule